// File: doc/BRIEF.md
# Speculative Branch Mask Tracker

This block keeps count of the conditional branches that are in flight and still unresolved in a superscalar pipeline, up to four at once. When a branch is dispatched, it receives a one-hot tag. The tag is the lowest-numbered one not in use. Every instruction dispatched after that branch is stamped with a 4-bit dependency mask. The mask has one bit set for each unresolved branch that the instruction sits behind. When all four tags are in use, the block raises a stall and refuses the branch.

The execution side reports the outcome of a branch with a resolve event. The event carries the branch tag and a flag that says whether the branch was mispredicted.

- **Correct outcome:** the block broadcasts a clear vector. That branch's bit is removed from the live mask and from every recorded instruction mask.
- **Misprediction:** the block broadcasts a kill vector. It holds the failing tag and every tag allocated after it. All of those tags return to the free pool in the same cycle. Any recorded instruction whose mask meets the kill vector is dropped and is never written back.

An eight-entry table of recorded instructions is kept so that kills and clears are visible at the ports. Each entry holds a valid bit and a mask.

Each tag is managed by a two-state machine:
- **TAG_FREE:** the tag is not in use. The transition *allocate* moves it to TAG_PENDING when a granted branch picks this tag.
- **TAG_PENDING:** the branch is unresolved. The transition *release* returns it to TAG_FREE when a correct outcome or a kill covers the tag.

Each tag also remembers which tags were already pending when it was allocated. This is what defines "younger" for a kill, independent of the tag numbers. Within one cycle, the order of effect is: the resolve is applied first, then instruction dispatch, then branch allocation.

Top module: `bmt_tracker`

## Requirements
- R1: After reset, no tag is pending (`cur_mask` = 0), `br_stall` is 0, all table entries are invalid, and `kill_vec` and `clear_vec` are 0.
- R2: While at least one tag is free, `br_tag` is one-hot and names the lowest-numbered free tag; bit i stands for tag i. A request in that cycle makes the tag pending from the next cycle.
- R3: When all four tags are pending, `br_stall` is 1 and a branch request is refused; no new tag becomes pending.
- R4: A correct resolve drives `clear_vec` equal to `res_tag` and `kill_vec` to 0 in that cycle. From the next cycle the tag is free and its bit is absent from every table entry's mask.
- R5: A mispredicted resolve drives `kill_vec` to the resolved tag together with every tag allocated after it, and `clear_vec` to 0. All those tags are free from the next cycle, and tags allocated earlier stay pending.
- R6: A valid table entry whose mask shares a bit with `kill_vec` is invalid from the next cycle; entries with no shared bit stay valid.
- R7: `ins_mask` equals the pending tags minus any tags being released by a resolve in the same cycle, and a dispatched instruction records that mask in slot `ins_slot`.
- R8: An instruction dispatched in the same cycle as a branch allocation does not carry the new branch's bit.
- R9: A valid table entry never holds a mask bit for a tag that is not pending.
- R10: Age follows allocation order, not tag number: a freed tag that is reallocated counts as younger than every tag that was still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_req | input | 1 | Branch dispatch request |
| br_stall | output | 1 | All tags pending; branch refused |
| br_tag | output | 4 | One-hot tag offered to the branch |
| ins_valid | input | 1 | Instruction dispatch |
| ins_slot | input | 3 | Table entry written by the instruction |
| ins_mask | output | 4 | Dependency mask for an instruction dispatched now |
| res_valid | input | 1 | Branch resolve event |
| res_tag | input | 4 | One-hot tag being resolved |
| res_mispredict | input | 1 | 1 = mispredicted, 0 = correct |
| kill_vec | output | 4 | Tags squashed this cycle |
| clear_vec | output | 4 | Tag released as correct this cycle |
| cur_mask | output | 4 | Tags currently pending |
| slot_valid | output | 8 | Valid bit of each table entry |
| slot_mask | output | 32 | Masks of the table entries, entry i in bits [4i+3:4i] |

## Verification
The assertions take for granted that a resolve names exactly one tag, and that this tag is pending. They also take for granted that at most one resolve arrives per cycle. Both are required by the kill-window and release checks.

The stimulus resolves only tags it has seen granted and still holds as pending in its own model, one event per cycle. It writes table entries only within the eight slots. It reaches the full and reused-tag cases by ordered allocation sequences, not by random tags.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    typedef enum logic {
        TAG_FREE    = 1'b0,
        TAG_PENDING = 1'b1
    } tag_state_e;
endpackage

// File: rtl/bmt_tag_pick.sv
module bmt_tag_pick #(
    parameter int NUM_TAGS = 4
) (
    input  logic [NUM_TAGS-1:0] busy,
    output logic [NUM_TAGS-1:0] pick,
    output logic                full
);
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (!busy[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign full = &busy;
endmodule

// File: rtl/bmt_tag_slot.sv
module bmt_tag_slot
    import bmt_pkg::*;
#(
    parameter int NUM_TAGS = 4,
    parameter int IDX      = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc,
    input  logic [NUM_TAGS-1:0] release_vec,
    input  logic [NUM_TAGS-1:0] snapshot,
    output logic                busy,
    output logic [NUM_TAGS-1:0] older
);
    tag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TAG_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TAG_FREE:    if (alloc)            state_d = TAG_PENDING;
            TAG_PENDING: if (release_vec[IDX]) state_d = TAG_FREE;
            default:                           state_d = TAG_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else if (alloc) begin
            older <= snapshot;
        end else begin
            older <= older & ~release_vec;
        end
    end

    assign busy = (state_q == TAG_PENDING);

    AST_NO_DOUBLE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state_q == TAG_FREE)); // R2
endmodule

// File: rtl/bmt_ins_table.sv
module bmt_ins_table #(
    parameter int NUM_TAGS  = 4,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          disp_valid,
    input  logic [SLOT_W-1:0]             disp_slot,
    input  logic [NUM_TAGS-1:0]           disp_mask,
    input  logic [NUM_TAGS-1:0]           kill_vec,
    input  logic [NUM_TAGS-1:0]           clear_vec,
    output logic [NUM_SLOTS-1:0]          valid_o,
    output logic [NUM_SLOTS*NUM_TAGS-1:0] mask_o
);
    for (genvar e = 0; e < NUM_SLOTS; e++) begin : g_entry
        logic                vld_q;
        logic [NUM_TAGS-1:0] msk_q;
        logic                hit;

        assign hit = disp_valid && (disp_slot == SLOT_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                msk_q <= '0;
            end else if (hit) begin
                vld_q <= 1'b1;
                msk_q <= disp_mask;
            end else begin
                if (|(msk_q & kill_vec)) vld_q <= 1'b0;
                msk_q <= msk_q & ~clear_vec;
            end
        end

        assign valid_o[e]                      = vld_q;
        assign mask_o[e*NUM_TAGS +: NUM_TAGS]  = msk_q;

        AST_KILL_DROPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q && |(msk_q & kill_vec) && !hit) |=> !vld_q); // R6
    end
endmodule

// File: rtl/bmt_tracker.sv
module bmt_tracker #(
    parameter int NUM_TAGS  = 4,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          br_req,
    output logic                          br_stall,
    output logic [NUM_TAGS-1:0]           br_tag,
    input  logic                          ins_valid,
    input  logic [SLOT_W-1:0]             ins_slot,
    output logic [NUM_TAGS-1:0]           ins_mask,
    input  logic                          res_valid,
    input  logic [NUM_TAGS-1:0]           res_tag,
    input  logic                          res_mispredict,
    output logic [NUM_TAGS-1:0]           kill_vec,
    output logic [NUM_TAGS-1:0]           clear_vec,
    output logic [NUM_TAGS-1:0]           cur_mask,
    output logic [NUM_SLOTS-1:0]          slot_valid,
    output logic [NUM_SLOTS*NUM_TAGS-1:0] slot_mask
);
    logic [NUM_TAGS-1:0] busy;
    logic [NUM_TAGS-1:0] older [NUM_TAGS];
    logic [NUM_TAGS-1:0] younger;
    logic [NUM_TAGS-1:0] release_vec;
    logic [NUM_TAGS-1:0] pick;
    logic                full;
    logic                grant;

    bmt_tag_pick #(.NUM_TAGS(NUM_TAGS)) i_pick (
        .busy (busy),
        .pick (pick),
        .full (full)
    );

    assign grant = br_req && !full;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        bmt_tag_slot #(.NUM_TAGS(NUM_TAGS), .IDX(t)) i_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (grant && pick[t]),
            .release_vec (release_vec),
            .snapshot    (busy & ~release_vec),
            .busy        (busy[t]),
            .older       (older[t])
        );
        assign younger[t] = busy[t] && |(older[t] & res_tag);
    end

    assign kill_vec    = (res_valid &&  res_mispredict) ? (res_tag | younger) : '0;
    assign clear_vec   = (res_valid && !res_mispredict) ? res_tag : '0;
    assign release_vec = kill_vec | clear_vec;

    assign ins_mask = busy & ~release_vec;
    assign cur_mask = busy;
    assign br_stall = full;
    assign br_tag   = pick;

    bmt_ins_table #(.NUM_TAGS(NUM_TAGS), .NUM_SLOTS(NUM_SLOTS)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_valid (ins_valid),
        .disp_slot  (ins_slot),
        .disp_mask  (ins_mask),
        .kill_vec   (kill_vec),
        .clear_vec  (clear_vec),
        .valid_o    (slot_valid),
        .mask_o     (slot_mask)
    );

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_stall) |=> ((cur_mask & ~$past(cur_mask)) == '0)); // R3
    AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_mispredict) |=> ((cur_mask & $past(res_tag)) == '0)); // R4
    AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |=> ((cur_mask & $past(kill_vec)) == '0)); // R5

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_live
        AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] |-> ((slot_mask[s*NUM_TAGS +: NUM_TAGS] & ~cur_mask) == '0)); // R9
    end
endmodule

// File: tb/test_bmt_tracker.sv
module test_bmt_tracker;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_req = 1'b0, ins_valid = 1'b0, res_valid = 1'b0, res_mispredict = 1'b0;
    logic [2:0]  ins_slot = '0;
    logic [3:0]  res_tag = '0;
    logic        br_stall;
    logic [3:0]  br_tag, ins_mask, kill_vec, clear_vec, cur_mask;
    logic [7:0]  slot_valid;
    logic [31:0] slot_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bmt_tracker i_bmt_tracker (
        .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_stall(br_stall), .br_tag(br_tag),
        .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_mask(ins_mask),
        .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict),
        .kill_vec(kill_vec), .clear_vec(clear_vec), .cur_mask(cur_mask),
        .slot_valid(slot_valid), .slot_mask(slot_mask)
    );

    typedef enum int {OB_CUR, OB_STALL, OB_TAG, OB_KILL, OB_CLEAR, OB_IMASK, OB_VALID, OB_LIVEMASK} obs_e;
    typedef struct {
        string       rq;
        obs_e        what;
        logic [31:0] exp;
    } item_t;
    item_t sbq[$];

    task automatic expect_item(input string rq, input obs_e what, input logic [31:0] exp);
        item_t it;
        it.rq = rq; it.what = what; it.exp = exp;
        sbq.push_back(it);
    endtask

    function automatic logic [31:0] observe(input obs_e what);
        logic [31:0] m;
        m = '0;
        case (what)
            OB_CUR:   return {28'd0, cur_mask};
            OB_STALL: return {31'd0, br_stall};
            OB_TAG:   return {28'd0, br_tag};
            OB_KILL:  return {28'd0, kill_vec};
            OB_CLEAR: return {28'd0, clear_vec};
            OB_IMASK: return {28'd0, ins_mask};
            OB_VALID: return {24'd0, slot_valid};
            default: begin
                for (int s = 0; s < 8; s++)
                    if (slot_valid[s]) m[4*s +: 4] = slot_mask[4*s +: 4];
                return m;
            end
        endcase
    endfunction

    // monitor: compares every queued expectation against what the design shows now
    task automatic drain();
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = observe(it.what);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s actual %h expected %h", it.rq, it.what.name(), act, it.exp);
            end
        end
    endtask

    // driver: apply inputs after a falling edge
    task automatic drive(input logic br, input logic iv, input logic [2:0] is,
                         input logic rv, input logic [3:0] rt, input logic rm);
        @(negedge clk);
        br_req = br; ins_valid = iv; ins_slot = is;
        res_valid = rv; res_tag = rt; res_mispredict = rm;
        #2;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        br_req = 0; ins_valid = 0; res_valid = 0; res_tag = '0; res_mispredict = 0;
        #1;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        // R1 reset state
        expect_item("R1", OB_CUR, 0);
        expect_item("R1", OB_STALL, 0);
        expect_item("R1", OB_VALID, 0);
        expect_item("R1", OB_KILL, 0);
        expect_item("R1", OB_CLEAR, 0);
        drain();

        // R2/R8: allocate tags 0..3, one instruction per cycle with each
        for (int k = 0; k < 4; k++) begin
            drive(1, 1, 3'(k), 0, 0, 0);
            expect_item("R2", OB_TAG, 32'(1 << k));
            expect_item("R8", OB_IMASK, 32'((1 << k) - 1));
            drain();
            tick();
            expect_item("R2", OB_CUR, 32'((1 << (k + 1)) - 1));
            drain();
        end

        // R3: full -> stall, refused
        drive(1, 1, 3'd4, 0, 0, 0);
        expect_item("R3", OB_STALL, 1);
        expect_item("R7", OB_IMASK, 4'hF);
        drain();
        tick();
        expect_item("R3", OB_CUR, 4'hF);
        drain();

        // R4/R7: correct resolve of tag0 with a same-cycle instruction
        drive(0, 1, 3'd5, 1, 4'b0001, 0);
        expect_item("R4", OB_CLEAR, 4'b0001);
        expect_item("R4", OB_KILL, 0);
        expect_item("R7", OB_IMASK, 4'b1110);
        drain();
        tick();
        expect_item("R4", OB_CUR, 4'b1110);
        expect_item("R4", OB_VALID, 8'h3F);
        expect_item("R4", OB_LIVEMASK, 32'h00EE6200);
        expect_item("R3", OB_STALL, 0);
        drain();

        // R10/R8: tag0 reused, now youngest
        drive(1, 1, 3'd6, 0, 0, 0);
        expect_item("R10", OB_TAG, 4'b0001);
        expect_item("R8", OB_IMASK, 4'b1110);
        drain();
        tick();
        expect_item("R10", OB_CUR, 4'hF);
        expect_item("R10", OB_VALID, 8'h7F);
        drain();

        // R5/R6/R10: mispredict tag2 -> kills tag3 and reused tag0, keeps tag1
        drive(0, 1, 3'd7, 1, 4'b0100, 1);
        expect_item("R5", OB_KILL, 4'b1101);
        expect_item("R5", OB_CLEAR, 0);
        expect_item("R7", OB_IMASK, 4'b0010);
        drain();
        tick();
        expect_item("R5", OB_CUR, 4'b0010);
        expect_item("R6", OB_VALID, 8'h87);
        expect_item("R6", OB_LIVEMASK, 32'h20000200);
        drain();

        // R4/R6: correct resolve of tag1, survivors stay valid
        drive(0, 0, 3'd0, 1, 4'b0010, 0);
        expect_item("R4", OB_CLEAR, 4'b0010);
        drain();
        tick();
        expect_item("R4", OB_CUR, 0);
        expect_item("R6", OB_VALID, 8'h87);
        expect_item("R9", OB_LIVEMASK, 0);
        drain();

        // R2: lowest free after everything released
        drive(0, 0, 3'd0, 0, 0, 0);
        expect_item("R2", OB_TAG, 4'b0001);
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule